// File: doc/BRIEF.md
# Edge-Triggered Multi-Input Event Capturer

This block watches twelve digital inputs and turns selected transitions on them into event records. Each input has its own enable bit and its own polarity bit, so one pin can record rising edges while its neighbour records falling edges. The block synchronises every input and detects edges per pin. It then issues one record for each detected edge to a downstream write port that uses a valid/ready handshake. A record is one event-code byte plus a 56-bit BCD timestamp, which is copied from a calendar bus at the moment the record is issued.

When edges arrive together on several pins, each becomes its own record. These records leave in ascending pin order. Detected edges wait in a per-pin pending register, so back-pressure from the sink loses nothing. A further edge on a pin that is already waiting merges with the waiting edge.

The block also provides the synchronised level of every pin as a pass-through value, split into two bytes. It drives an active-low activity interrupt, enabled per pin.

The issuer is a two-state machine:
- In `ST_IDLE` it waits. When any pending bit is set, it takes the *load* transition to `ST_SEND`: it picks the lowest pending pin, clears that bit, and latches the code and the timestamp.
- In `ST_SEND` it presents the record. It takes the *accept* transition back to `ST_IDLE` on the cycle the sink is ready.

Top module: `edge_event_capture`

## Requirements
- R1: A pin whose enable bit is 0 never produces a record, whatever its input does.
- R2: With polarity bit 1 a pin records low-to-high transitions only. With polarity bit 0 it records high-to-low transitions only.
- R3: Edges detected in the same cycle on several enabled pins are issued lowest pin index first.
- R4: A record's code byte holds the pin index in bits 3:0 and the edge direction in bit 4 (1 = rising, 0 = falling); bits 7:5 are 0. The timestamp field is the value of `ts_in` in the cycle the record is loaded. Byte 0 of `ts_in` is seconds, byte 1 minutes, byte 2 hours, byte 3 day of week, byte 4 date, byte 5 month and byte 6 year, all BCD.
- R5: Every edge on an enabled pin that matches its polarity produces exactly one record, even while the sink holds `rec_ready` low.
- R6: An edge on a pin whose previous edge is still pending (detected but not yet loaded) merges with it and yields no extra record.
- R7: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_code` and `rec_ts` hold their values.
- R8: `lvl_hi` shows the synchronised levels of pins 11..4 (bit 7 = pin 11). `lvl_lo` bits 3:0 show pins 3..0, and bits 7:4 are 0. Each level follows its input after a two-flop synchroniser.
- R9: `irq_n` is 0 while any pin with its interrupt-enable bit set has an edge that is pending or is being presented and not yet accepted. Otherwise it is 1.
- R10: After reset `rec_valid` is 0, `irq_n` is 1 and both level bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 12 | Asynchronous event inputs |
| pin_en | input | 12 | Per-pin recording enable |
| pin_pol | input | 12 | Per-pin polarity, 1 = rising, 0 = falling |
| irq_en | input | 12 | Per-pin interrupt enable |
| ts_in | input | 56 | BCD calendar time, seconds in byte 0 up to year in byte 6 |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Sink accepts the record |
| rec_code | output | 8 | Event code: index in 3:0, direction in bit 4 |
| rec_ts | output | 56 | Timestamp latched when the record was loaded |
| lvl_hi | output | 8 | Synchronised levels of pins 11..4 |
| lvl_lo | output | 8 | Synchronised levels of pins 3..0 in bits 3:0 |
| irq_n | output | 1 | Active-low activity interrupt |

## Verification
The assertions check the handshake hold rule, the fixed-zero bits of the code byte and the level byte, and the range of the index on every cycle. They also check that a presented record for an interrupt-enabled pin keeps `irq_n` low. Only the bench scenarios can show ascending issue order for simultaneous edges, polarity and enable filtering, merging of repeated edges while a pin is pending, and loss-free delivery under back-pressure. Those properties concern which records appear over many cycles, not a relation between signals in one cycle.

// File: rtl/edr_pkg.sv
package edr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } issue_state_t;

    localparam int CODE_W   = 8;
    localparam int DIR_BIT  = 4;
endpackage

// File: rtl/edr_sync_edge.sv
module edr_sync_edge #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] pin_en,
    input  logic [N-1:0] pin_pol,
    output logic [N-1:0] level,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[g] = sync_q;
        assign hit[g]   = pin_en[g] &
                          (pin_pol[g] ? (sync_q & ~prev_q) : (~sync_q & prev_q));
    end
endmodule

// File: rtl/edr_pending.sv
module edr_pending #(
    parameter int N    = 12,
    parameter int IW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  hit,
    input  logic [N-1:0]  hit_dir,
    input  logic          take,
    output logic [N-1:0]  pend,
    output logic          pend_any,
    output logic [IW-1:0] pick_idx,
    output logic          pick_dir
);
    logic [N-1:0] pend_q, dir_q, clr;

    always_comb begin
        pick_idx = '0;
        pick_dir = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_idx = IW'(i);
                pick_dir = dir_q[i];
            end
        end
    end

    always_comb begin
        clr = '0;
        if (take) clr[pick_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            dir_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | hit;
            dir_q  <= (dir_q & ~hit) | (hit_dir & hit);
        end
    end

    assign pend     = pend_q;
    assign pend_any = |pend_q;
endmodule

// File: rtl/edr_issuer.sv
module edr_issuer
    import edr_pkg::*;
#(
    parameter int IW  = 4,
    parameter int TSW = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  logic [IW-1:0]     pick_idx,
    input  logic              pick_dir,
    input  logic [TSW-1:0]    ts_in,
    input  logic              rec_ready,
    output logic              take,
    output logic              rec_valid,
    output logic [CODE_W-1:0] rec_code,
    output logic [TSW-1:0]    rec_ts
);
    issue_state_t state_q, state_d;
    logic [CODE_W-1:0] code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (pend_any) begin
                take    = 1'b1;
                state_d = ST_SEND;
            end
            ST_SEND: if (rec_ready) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        code_d            = '0;
        code_d[IW-1:0]    = pick_idx;
        code_d[DIR_BIT]   = pick_dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_code <= '0;
            rec_ts   <= '0;
        end else if (take) begin
            rec_code <= code_d;
            rec_ts   <= ts_in;
        end
    end

    assign rec_valid = (state_q == ST_SEND);
endmodule

// File: rtl/edge_event_capture.sv
module edge_event_capture #(
    parameter int N_PINS = 12,
    parameter int TS_W   = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] pin_en,
    input  logic [N_PINS-1:0] pin_pol,
    input  logic [N_PINS-1:0] irq_en,
    input  logic [TS_W-1:0]   ts_in,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [7:0]        rec_code,
    output logic [TS_W-1:0]   rec_ts,
    output logic [7:0]        lvl_hi,
    output logic [7:0]        lvl_lo,
    output logic              irq_n
);
    localparam int IDX_W  = $clog2(N_PINS);
    localparam int LO_N   = 4;
    localparam int HI_N   = N_PINS - LO_N;

    logic [N_PINS-1:0] level, hit, pend, flight;
    logic              pend_any, pick_dir, take;
    logic [IDX_W-1:0]  pick_idx;

    edr_sync_edge #(.N(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_en  (pin_en),
        .pin_pol (pin_pol),
        .level   (level),
        .hit     (hit)
    );

    edr_pending #(.N(N_PINS), .IW(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .hit_dir  (pin_pol),
        .take     (take),
        .pend     (pend),
        .pend_any (pend_any),
        .pick_idx (pick_idx),
        .pick_dir (pick_dir)
    );

    edr_issuer #(.IW(IDX_W), .TSW(TS_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (pend_any),
        .pick_idx  (pick_idx),
        .pick_dir  (pick_dir),
        .ts_in     (ts_in),
        .rec_ready (rec_ready),
        .take      (take),
        .rec_valid (rec_valid),
        .rec_code  (rec_code),
        .rec_ts    (rec_ts)
    );

    always_comb begin
        flight = '0;
        if (rec_valid) flight[rec_code[IDX_W-1:0]] = 1'b1;
    end

    assign irq_n  = ~|((pend | flight) & irq_en);
    assign lvl_hi = 8'(level[N_PINS-1:LO_N]);
    assign lvl_lo = 8'(level[LO_N-1:0]);

    if (HI_N != 8) begin : g_bad_cfg
        initial $error("pass-through packing expects twelve pins");
    end
endmodule

// File: rtl/edge_event_capture_chk.sv
module edge_event_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] irq_en,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic [7:0]  rec_code,
    input logic [55:0] rec_ts,
    input logic [7:0]  lvl_lo,
    input logic        irq_n
);
    logic [15:0] irq_en_w;
    assign irq_en_w = {4'b0, irq_en};

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_code) && $stable(rec_ts)));

    // R4
    code_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_code[7:5] == 3'b000 && rec_code[3:0] < 4'd12));

    // R8
    lvl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_lo[7:4] == 4'b0000);

    // R9
    irq_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && irq_en_w[rec_code[3:0]]) |-> !irq_n);
endmodule

bind edge_event_capture edge_event_capture_chk u_chk (.*);

// File: tb/sim_edge_event_capture.sv
module sim_edge_event_capture;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic [11:0] pin_in = 0, pin_en = 0, pin_pol = 0, irq_en = 0;
    logic [55:0] ts_in = 0;
    logic        rec_valid, rec_ready = 0, irq_n;
    logic [7:0]  rec_code, lvl_hi, lvl_lo;
    logic [55:0] rec_ts;

    int checks = 0, failures = 0;
    logic [63:0] expq[$];
    logic [63:0] gotq[$];

    always #(CLK_P/2) clk = ~clk;

    edge_event_capture u0 (.*);

    always @(negedge clk)
        if (rst_n && rec_valid && rec_ready) gotq.push_back({rec_code, rec_ts});

    function automatic logic [63:0] mk(input int idx, input bit dir, input logic [55:0] ts);
        return {3'b000, dir, 4'(idx), ts};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic compare(input string req);
        chk(gotq.size() == expq.size(), req, 64'(gotq.size()), 64'(expq.size()));
        for (int i = 0; i < expq.size() && i < gotq.size(); i++)
            chk(gotq[i] == expq[i], req, gotq[i], expq[i]);
        gotq.delete();
        expq.delete();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [7:0] c0;
        void'($urandom(32'd4242));
        cyc(3);
        // R10 reset state
        chk(rec_valid == 0, "R10", 64'(rec_valid), 0);
        chk(irq_n == 1, "R10", 64'(irq_n), 1);
        chk({lvl_hi, lvl_lo} == 0, "R10", 64'({lvl_hi, lvl_lo}), 0);
        rst_n = 1;
        cyc(2);

        // R3 R5 simultaneous edges under back-pressure
        pin_en = '1; pin_pol = '1; irq_en = '1;
        ts_in = 56'h09_05_17_03_14_30_45;
        pin_in = 12'b0100_1000_0011;
        cyc(10);
        chk(rec_valid == 1 && rec_code == 8'h10, "R3", 64'(rec_code), 64'h10);
        chk(irq_n == 0, "R9", 64'(irq_n), 0);
        c0 = rec_code;
        cyc(5);
        // R7 held while not ready
        chk(rec_code == c0 && rec_valid, "R7", 64'(rec_code), 64'(c0));
        rec_ready = 1;
        cyc(20);
        foreach (expq[i]) ;
        expq.push_back(mk(0, 1, ts_in));
        expq.push_back(mk(1, 1, ts_in));
        expq.push_back(mk(7, 1, ts_in));
        expq.push_back(mk(10, 1, ts_in));
        compare("R3 R5 R4");
        chk(irq_n == 1, "R9", 64'(irq_n), 1);
        pin_in = 0;
        cyc(20);
        gotq.delete();

        // R2 falling polarity on pin 3
        pin_pol[3] = 0;
        ts_in = 56'h10_12_31_06_23_59_58;
        pin_in[3] = 1; cyc(15);
        pin_in[3] = 0; cyc(15);
        expq.push_back(mk(3, 0, ts_in));
        compare("R2");

        // R1 disabled pin 5
        pin_en[5] = 0;
        pin_in[5] = 1; cyc(15);
        pin_in[5] = 0; cyc(15);
        chk(rec_valid == 0, "R1", 64'(rec_valid), 0);
        compare("R1");

        // R6 merge while pending
        rec_ready = 0;
        ts_in = 56'h11_01_01_01_00_00_01;
        pin_in[2] = 1; cyc(8);
        pin_in[2] = 0; cyc(8);
        pin_in[2] = 1; cyc(8);
        pin_in[2] = 0; cyc(8);
        pin_in[2] = 1; cyc(8);
        rec_ready = 1; cyc(15);
        expq.push_back(mk(2, 1, ts_in));
        expq.push_back(mk(2, 1, ts_in));
        compare("R6");
        pin_in[2] = 0; cyc(15);

        // R8 pass-through levels
        pin_en = 0;
        pin_in = 12'hA5C; cyc(4);
        chk(lvl_hi == 8'hA5, "R8", 64'(lvl_hi), 64'hA5);
        chk(lvl_lo == 8'h0C, "R8", 64'(lvl_lo), 64'h0C);
        pin_in = 0; cyc(6);

        // R9 interrupt only for enabled pins
        pin_en = '1; pin_pol = '1; irq_en = 12'h200; rec_ready = 0;
        pin_in[8] = 1; cyc(10);
        chk(irq_n == 1, "R9", 64'(irq_n), 1);
        pin_in[9] = 1; cyc(10);
        chk(irq_n == 0, "R9", 64'(irq_n), 0);
        rec_ready = 1; cyc(15);
        chk(irq_n == 1, "R9", 64'(irq_n), 1);
        expq.push_back(mk(8, 1, ts_in));
        expq.push_back(mk(9, 1, ts_in));
        compare("R9 R5");
        pin_in = 0; cyc(15);
        gotq.delete();

        // random single-pin toggles: R1 R2 R4 R5
        for (int s = 0; s < 80; s++) begin
            int p;
            bit nv;
            if (s % 10 == 0) begin
                pin_en = 12'($urandom);
                pin_pol = 12'($urandom);
                cyc(6);
            end
            p = $urandom_range(0, 11);
            ts_in = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
            nv = ~pin_in[p];
            pin_in[p] = nv;
            if (pin_en[p] && nv == pin_pol[p]) expq.push_back(mk(p, pin_pol[p], ts_in));
            cyc(12);
        end
        compare("R5 random");
        finish_run();
    end
endmodule